// File: doc/BRIEF.md
# Quadrature Sample Output Formatter

This block sits between a sine/cosine lookup and the two 16-bit output buses of a quadrature oscillator. Each clock it receives a two's-complement sine sample, a cosine sample and the 28-bit phase word that produced them. It presents them in one of two ways. In parallel mode both buses reload every clock. In serial mode a sample pair is captured into shift registers and streamed one bit per clock. The most-significant-bit-first stream comes out on bit 15 of each bus and the least-significant-bit-first stream on bit 0. An active-low word-start strobe flags the cycle in which the first bit of a freshly loaded word is present.

The mode, number format, test select and load enable inputs are all captured by a register before they act. An offset-binary option flips the sign bit of both samples, which suits unsigned converters. A test option, honoured only in parallel mode, replaces the samples with the phase word so that the lookup address can be observed. Each bus has an active-low output enable, modelled here as a valid flag that also forces the bus to zero.

Top module: `qsample_fmt`

## Requirements
- R1: `load_n`, `par_mode`, `twos_fmt` and `test_en` are captured on a rising edge and act only from the following rising edge. A format change applied just before edge k still leaves the sample loaded at edge k in the old format.
- R2: In parallel mode (registered `par_mode` = 1, registered `test_en` = 0), each rising edge loads the formatted `sin_in`/`cos_in` onto `sin_out`/`cos_out`.
- R3: In serial mode (registered `par_mode` = 0), an edge with registered `load_n` = 0 loads both shift registers. Each edge with registered `load_n` = 1 shifts them. Bit 15 of each bus carries the word most significant bit first, and a zero enters behind the last bit.
- R4: In serial mode, bit 0 of each bus carries the word least significant bit first. Copies of the word's bit 15 follow once bit 15 has been sent.
- R5: `strobe_n` is low for exactly the cycle after a serial load edge, when the first bits are on bits 15 and 0. Otherwise it is high, and it is always high in parallel mode, even while `load_n` is held low.
- R6: When registered `twos_fmt` = 0, bit 15 of each word is inverted when the word is loaded (offset binary). This applies in both modes.
- R7: With registered `par_mode` = 1 and registered `test_en` = 1, `sin_out` = phase[27:12] and `cos_out` = {phase[11:0], 4'b0000}. In serial mode `test_en` has no effect.
- R8: `sin_oe_n` = 1 forces `sin_out` to zero and `sin_valid` low in the same cycle, and `cos_oe_n` does the same for the cosine bus. The other bus is unaffected.
- R9: In serial mode, bits 14..1 of both buses are zero.
- R10: Reset (`rst_n` = 0) clears all data registers and sets `strobe_n` high. It also sets the captured controls to parallel, two's complement, test off and load inactive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sin_in | input | 16 | Two's-complement sine sample from the lookup |
| cos_in | input | 16 | Two's-complement cosine sample from the lookup |
| phase_in | input | 28 | Phase word that addresses the lookup |
| load_n | input | 1 | Serial load enable, active low (shift while high) |
| par_mode | input | 1 | 1 = parallel buses, 0 = serial streams |
| twos_fmt | input | 1 | 1 = two's complement, 0 = offset binary |
| test_en | input | 1 | Drive the phase onto the buses (parallel mode only) |
| sin_oe_n | input | 1 | Sine bus output enable, active low |
| cos_oe_n | input | 1 | Cosine bus output enable, active low |
| sin_out | output | 16 | Sine bus |
| cos_out | output | 16 | Cosine bus |
| sin_valid | output | 1 | Sine bus is driven |
| cos_valid | output | 1 | Cosine bus is driven |
| strobe_n | output | 1 | Word-start strobe, active low, serial mode only |

## Verification
The assertions check the following on every cycle: the strobe follows the registered mode and load enable, the zero fill enters the MSB-first shifter, the sign bit of the LSB-first shifter holds while shifting, the phase is routed in test mode, and the enables blank the buses. Other behaviour can only be shown by the bench's scenarios. These are the exact bit order of complete serial words in both formats, the tail of zeros and sign copies after a word, the one-edge lag of a format change, and the fact that the test select has no effect on a serial stream. The bench sweeps hundreds of parallel samples in both formats and streams words of either sign.

// File: rtl/qfmt_pkg.sv
`timescale 1ns/1ps
package qfmt_pkg;
  // Control inputs as captured one edge before use.
  typedef struct packed {
    logic load_n;  // serial load enable, active low
    logic par;     // 1 = parallel, 0 = serial
    logic twos;    // 1 = two's complement, 0 = offset binary
    logic test;    // phase bypass (parallel only)
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{load_n: 1'b1, par: 1'b1, twos: 1'b1, test: 1'b0};
endpackage

// File: rtl/qfmt_ctrl_sync.sv
`timescale 1ns/1ps
module qfmt_ctrl_sync
  import qfmt_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  ctrl_t ctrl_d,
  output ctrl_t ctrl_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= CTRL_RST;
    else        ctrl_q <= ctrl_d;
  end
endmodule

// File: rtl/qfmt_test_split.sv
`timescale 1ns/1ps
module qfmt_test_split #(
  parameter int SAMPLE_W = 16,
  parameter int PHASE_W  = 28
) (
  input  logic [PHASE_W-1:0]  phase,
  output logic [SAMPLE_W-1:0] hi_word,
  output logic [SAMPLE_W-1:0] lo_word
);
  localparam int PAD_W = 2*SAMPLE_W - PHASE_W;  // must be >= 1

  logic [2*SAMPLE_W-1:0] phase_ext;
  assign phase_ext = {phase, {PAD_W{1'b0}}};
  assign hi_word   = phase_ext[2*SAMPLE_W-1:SAMPLE_W];
  assign lo_word   = phase_ext[SAMPLE_W-1:0];
endmodule

// File: rtl/qfmt_lane.sv
`timescale 1ns/1ps
module qfmt_lane
  import qfmt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  ctrl_t        ctrl_q,
  input  logic [W-1:0] sample,
  input  logic [W-1:0] test_word,
  input  logic         oe_n,
  output logic [W-1:0] bus,
  output logic         valid,
  output logic [W-1:0] msb_sr,
  output logic [W-1:0] lsb_sr
);
  function automatic logic [W-1:0] apply_fmt(input logic [W-1:0] w, input logic twos);
    return {w[W-1] ^ ~twos, w[W-2:0]};
  endfunction

  logic [W-1:0] par_word;
  logic [W-1:0] fmt_word;
  logic [W-1:0] word_sel;

  assign fmt_word = apply_fmt(sample, ctrl_q.twos);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_word <= '0;
      msb_sr   <= '0;
      lsb_sr   <= '0;
    end else if (ctrl_q.par) begin
      par_word <= ctrl_q.test ? test_word : fmt_word;
    end else if (!ctrl_q.load_n) begin
      msb_sr <= fmt_word;
      lsb_sr <= fmt_word;
    end else begin
      msb_sr <= {msb_sr[W-2:0], 1'b0};
      lsb_sr <= {lsb_sr[W-1], lsb_sr[W-1:1]};
    end
  end

  always_comb begin
    if (ctrl_q.par) word_sel = par_word;
    else            word_sel = {msb_sr[W-1], {(W-2){1'b0}}, lsb_sr[0]};
  end

  assign bus   = oe_n ? '0 : word_sel;
  assign valid = ~oe_n;
endmodule

// File: rtl/qsample_fmt.sv
`timescale 1ns/1ps
module qsample_fmt
  import qfmt_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int PHASE_W  = 28
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] sin_in,
  input  logic [SAMPLE_W-1:0] cos_in,
  input  logic [PHASE_W-1:0]  phase_in,
  input  logic                load_n,
  input  logic                par_mode,
  input  logic                twos_fmt,
  input  logic                test_en,
  input  logic                sin_oe_n,
  input  logic                cos_oe_n,
  output logic [SAMPLE_W-1:0] sin_out,
  output logic [SAMPLE_W-1:0] cos_out,
  output logic                sin_valid,
  output logic                cos_valid,
  output logic                strobe_n
);
  localparam int LANES = 2;  // 0 = sine, 1 = cosine

  ctrl_t ctrl_d, ctrl_q;
  assign ctrl_d = '{load_n: load_n, par: par_mode, twos: twos_fmt, test: test_en};

  qfmt_ctrl_sync u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctrl_d (ctrl_d),
    .ctrl_q (ctrl_q)
  );

  logic [SAMPLE_W-1:0] test_hi, test_lo;
  qfmt_test_split #(.SAMPLE_W(SAMPLE_W), .PHASE_W(PHASE_W)) u_split (
    .phase   (phase_in),
    .hi_word (test_hi),
    .lo_word (test_lo)
  );

  // Named events for the checker.
  logic load_ev, shift_ev;
  assign load_ev  = ~ctrl_q.par & ~ctrl_q.load_n;
  assign shift_ev = ~ctrl_q.par &  ctrl_q.load_n;

  logic [SAMPLE_W-1:0] samp_a [LANES];
  logic [SAMPLE_W-1:0] test_a [LANES];
  logic                oe_a   [LANES];
  logic [SAMPLE_W-1:0] bus_a  [LANES];
  logic                vld_a  [LANES];
  logic [SAMPLE_W-1:0] msb_a  [LANES];
  logic [SAMPLE_W-1:0] lsb_a  [LANES];

  assign samp_a[0] = sin_in;
  assign samp_a[1] = cos_in;
  assign test_a[0] = test_hi;
  assign test_a[1] = test_lo;
  assign oe_a[0]   = sin_oe_n;
  assign oe_a[1]   = cos_oe_n;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    qfmt_lane #(.W(SAMPLE_W)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctrl_q    (ctrl_q),
      .sample    (samp_a[g]),
      .test_word (test_a[g]),
      .oe_n      (oe_a[g]),
      .bus       (bus_a[g]),
      .valid     (vld_a[g]),
      .msb_sr    (msb_a[g]),
      .lsb_sr    (lsb_a[g])
    );
  end

  assign sin_out   = bus_a[0];
  assign cos_out   = bus_a[1];
  assign sin_valid = vld_a[0];
  assign cos_valid = vld_a[1];

  // Word-start strobe: low in the cycle following a serial load edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_n <= 1'b1;
    else        strobe_n <= ~load_ev;
  end
endmodule

// File: rtl/qsample_fmt_chk.sv
`timescale 1ns/1ps
module qsample_fmt_chk #(
  parameter int SAMPLE_W = 16,
  parameter int PHASE_W  = 28
) (
  input logic                clk,
  input logic                rst_n,
  input logic                par_q,
  input logic                load_q,
  input logic                test_q,
  input logic                par_in,
  input logic                shift_ev,
  input logic [PHASE_W-1:0]  phase_in,
  input logic [SAMPLE_W-1:0] sin_out,
  input logic [SAMPLE_W-1:0] cos_out,
  input logic                sin_oe_n,
  input logic                cos_oe_n,
  input logic                sin_valid,
  input logic                cos_valid,
  input logic                strobe_n,
  input logic [SAMPLE_W-1:0] msb_s,
  input logic [SAMPLE_W-1:0] msb_c,
  input logic [SAMPLE_W-1:0] lsb_s,
  input logic [SAMPLE_W-1:0] lsb_c
);
  a_r5_strobe_par: assert property (@(posedge clk) disable iff (!rst_n)
    par_q |=> strobe_n);

  a_r5_strobe_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!par_q && !load_q) |=> !strobe_n);

  a_r5_strobe_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (!par_q && load_q) |=> strobe_n);

  a_r3_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    shift_ev |=> (msb_s[0] == 1'b0 && msb_c[0] == 1'b0));

  a_r4_sign_hold: assert property (@(posedge clk) disable iff (!rst_n)
    shift_ev |=> (lsb_s[SAMPLE_W-1] == $past(lsb_s[SAMPLE_W-1]) &&
                  lsb_c[SAMPLE_W-1] == $past(lsb_c[SAMPLE_W-1])));

  a_r7_test_route: assert property (@(posedge clk) disable iff (!rst_n)
    (par_q && test_q && par_in) |=>
      (sin_oe_n || sin_out == $past(phase_in[PHASE_W-1 -: SAMPLE_W])));

  a_r8_sin_blank: assert property (@(posedge clk) disable iff (!rst_n)
    sin_oe_n |-> (sin_out == '0 && !sin_valid));

  a_r8_cos_blank: assert property (@(posedge clk) disable iff (!rst_n)
    cos_oe_n |-> (cos_out == '0 && !cos_valid));
endmodule

bind qsample_fmt qsample_fmt_chk #(.SAMPLE_W(SAMPLE_W), .PHASE_W(PHASE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .par_q     (ctrl_q.par),
  .load_q    (ctrl_q.load_n),
  .test_q    (ctrl_q.test),
  .par_in    (par_mode),
  .shift_ev  (shift_ev),
  .phase_in  (phase_in),
  .sin_out   (sin_out),
  .cos_out   (cos_out),
  .sin_oe_n  (sin_oe_n),
  .cos_oe_n  (cos_oe_n),
  .sin_valid (sin_valid),
  .cos_valid (cos_valid),
  .strobe_n  (strobe_n),
  .msb_s     (msb_a[0]),
  .msb_c     (msb_a[1]),
  .lsb_s     (lsb_a[0]),
  .lsb_c     (lsb_a[1])
);

// File: tb/qsample_fmt_test.sv
`timescale 1ns/1ps
module qsample_fmt_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] sin_in, cos_in;
  logic [27:0] phase_in;
  logic        load_n, par_mode, twos_fmt, test_en, sin_oe_n, cos_oe_n;
  logic [15:0] sin_out, cos_out;
  logic        sin_valid, cos_valid, strobe_n;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  qsample_fmt uut (
    .clk(clk), .rst_n(rst_n), .sin_in(sin_in), .cos_in(cos_in), .phase_in(phase_in),
    .load_n(load_n), .par_mode(par_mode), .twos_fmt(twos_fmt), .test_en(test_en),
    .sin_oe_n(sin_oe_n), .cos_oe_n(cos_oe_n), .sin_out(sin_out), .cos_out(cos_out),
    .sin_valid(sin_valid), .cos_valid(cos_valid), .strobe_n(strobe_n)
  );

  // Offset binary is two's complement plus half scale, modulo 2^16.
  function automatic logic [15:0] expect_word(input logic [15:0] w, input logic twos);
    return twos ? w : 16'(w + 16'h8000);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // From one falling edge through a rising edge to the next falling edge.
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Stream one serial word pair and check every bit plus a tail.
  task automatic serial_word(input logic [15:0] ws, input logic [15:0] wc, input logic twos);
    logic [15:0] fs, fc;
    fs = expect_word(ws, twos);
    fc = expect_word(wc, twos);
    load_n = 1'b0; sin_in = ws; cos_in = wc; twos_fmt = twos;
    tick();                 // edge k: controls captured
    load_n = 1'b1;
    tick();                 // edge k+1: shift registers load
    sin_in = ~ws; cos_in = ~wc;  // later data must not disturb the stream
    chk("R5 strobe low on first bit", {31'd0, strobe_n}, 32'd0);
    for (int j = 0; j < 16; j++) begin
      if (j > 0) begin
        tick();
        chk("R5 strobe high while shifting", {31'd0, strobe_n}, 32'd1);
      end
      chk("R3 msb-first sine bit",  {31'd0, sin_out[15]}, {31'd0, fs[15-j]});
      chk("R3 msb-first cosine bit", {31'd0, cos_out[15]}, {31'd0, fc[15-j]});
      chk("R4 lsb-first sine bit",  {31'd0, sin_out[0]},  {31'd0, fs[j]});
      chk("R4 lsb-first cosine bit", {31'd0, cos_out[0]},  {31'd0, fc[j]});
      chk("R9 middle bits zero", {18'd0, sin_out[14:1]}, 32'd0);
    end
    for (int j = 0; j < 3; j++) begin
      tick();
      chk("R3 zero fill after word", {30'd0, sin_out[15], cos_out[15]}, 32'd0);
      chk("R4 sign fill after word", {30'd0, sin_out[0], cos_out[0]},
          {30'd0, fs[15], fc[15]});
    end
  endtask

  initial begin
    #1ms;
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sin_in = 16'h1234; cos_in = 16'h4321; phase_in = '0;
    load_n = 1'b1; par_mode = 1'b1; twos_fmt = 1'b1; test_en = 1'b0;
    sin_oe_n = 1'b0; cos_oe_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 reset sine bus", {16'd0, sin_out}, 32'd0);
    chk("R10 reset cosine bus", {16'd0, cos_out}, 32'd0);
    chk("R10 reset strobe high", {31'd0, strobe_n}, 32'd1);
    rst_n = 1'b1;
    tick();

    // R2: parallel sweep, two's complement
    for (int i = 0; i < 600; i++) begin
      logic [15:0] s, c;
      s = 16'(i * 40503);
      c = 16'(i * 9973 + 16'h7FF0);
      if (i == 1) s = 16'h8000;
      if (i == 2) s = 16'h7FFF;
      if (i == 3) s = 16'hFFFF;
      sin_in = s; cos_in = c;
      tick();
      chk("R2 parallel sine", {16'd0, sin_out}, {16'd0, s});
      chk("R2 parallel cosine", {16'd0, cos_out}, {16'd0, c});
      if (i % 100 == 0) chk("R5 strobe high in parallel", {31'd0, strobe_n}, 32'd1);
    end

    // R1: format change lags by one edge
    twos_fmt = 1'b0; sin_in = 16'h0001;
    tick();
    chk("R1 old format on capture edge", {16'd0, sin_out}, 32'h0001);
    sin_in = 16'h0002;
    tick();
    chk("R1 new format one edge later", {16'd0, sin_out}, 32'h8002);

    // R6: offset binary sweep
    for (int i = 0; i < 300; i++) begin
      logic [15:0] s, c;
      s = 16'(i * 26119 + 3);
      c = 16'(16'h8000 - i * 77);
      sin_in = s; cos_in = c;
      tick();
      chk("R6 offset binary sine", {16'd0, sin_out}, {16'd0, expect_word(s, 1'b0)});
      chk("R6 offset binary cosine", {16'd0, cos_out}, {16'd0, expect_word(c, 1'b0)});
    end
    twos_fmt = 1'b1;

    // R5: load_n low in parallel mode leaves strobe high
    load_n = 1'b0;
    tick(); tick(); tick();
    chk("R5 strobe high in parallel with load low", {31'd0, strobe_n}, 32'd1);
    load_n = 1'b1;

    // R7: test mode phase routing
    test_en = 1'b1;
    tick();
    for (int i = 0; i < 64; i++) begin
      logic [27:0] p;
      p = 28'(i * 4194319 + 28'h5A5A5A5);
      phase_in = p;
      tick();
      chk("R7 test sine bus", {16'd0, sin_out}, {16'd0, p[27:12]});
      chk("R7 test cosine bus", {16'd0, cos_out}, {16'd0, p[11:0], 4'h0});
    end

    // R8: output enables
    sin_oe_n = 1'b1;
    #1;
    chk("R8 sine bus blanked", {16'd0, sin_out}, 32'd0);
    chk("R8 sine valid low", {31'd0, sin_valid}, 32'd0);
    chk("R8 cosine untouched", {15'd0, cos_valid, cos_out}, {15'd0, 1'b1, phase_in[11:0], 4'h0});
    sin_oe_n = 1'b0; cos_oe_n = 1'b1;
    #1;
    chk("R8 cosine bus blanked", {15'd0, cos_valid, cos_out}, 32'd0);
    chk("R8 sine restored", {16'd0, sin_out}, {16'd0, phase_in[27:12]});
    cos_oe_n = 1'b0;
    @(negedge clk);

    // Serial mode; test_en stays high to show it is ignored (R7)
    par_mode = 1'b0;
    tick(); tick();
    chk("R5 strobe high in idle serial", {31'd0, strobe_n}, 32'd1);
    serial_word(16'hA5C3, 16'h1E2D, 1'b1);
    chk("R7 test ignored in serial", {18'd0, cos_out[14:1]}, 32'd0);
    test_en = 1'b0;
    serial_word(16'h3C5A, 16'hF00F, 1'b1);
    serial_word(16'h7FFF, 16'h8000, 1'b0);
    serial_word(16'h0001, 16'hFFFE, 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule